// File: doc/BRIEF.md
# Serial Byte Transmitter with Enable Sequencing

This block turns bytes into asynchronous serial frames on an idle-high line. A byte is offered on a valid/ready handshake and held in a one-entry holding register while the current frame shifts out. Every bit lasts a programmable number of clock cycles. The count restarts at each bit boundary.

Two controls govern the block. The block enable is a master switch. Dropping it stops the bit timer and forces the line high at the next clock edge. It also discards the frame in flight and the held byte, and clears every status flag. The divider value is an input, so the configuration is kept. The transmit enable arms the transmitter. Raising it opens a one-bit-time quiet interval before any frame may start, and the acknowledge output rises when that interval ends. Dropping and raising the transmit enable while a frame is on the line queues one idle character after that frame. That character is ten bit times of high level. Dropping the transmit enable for good lets the current frame finish and then leaves the line quiet. A completion flag tells software when the last frame has fully left the block, so a shutdown can wait for it before the block enable is removed.

Top module: `uart_tx_seq`

## Requirements
- R1: A frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts exactly D clock cycles, where D is `bit_div` (a value of 0 acts as 1). `txd` is high whenever no frame is being sent.
- R2: If both enables are sampled high at clock edge E0 after the transmit enable was low, `te_ack` is low through edge E0+D-1 and high from edge E0+D. No frame starts before `te_ack` is high.
- R3: Whenever `tx_en` is sampled low at a clock edge, `te_ack` is low after that edge.
- R4: `in_ready` is high only when `glob_en`, `tx_en` and `te_ack` are all high, the holding register is empty and no idle character is being sent.
- R5: If `tx_en` goes low and then high again while a frame is on the line, the line stays high for 10·D cycles after that frame's stop bit. During that time `te_ack` and `in_ready` are low, and `te_ack` rises when it ends. For a byte offered as soon as `in_ready` returns, the start bit begins 20·D+2 cycles after the previous start bit.
- R6: If `tx_en` goes low during a frame and stays low, that frame completes unchanged. Afterwards `txd` stays high and `in_ready` stays low.
- R7: `tx_done` rises at the end of a stop bit (or of an idle character) when no byte is held. It falls at the clock edge that accepts a new byte.
- R8: One edge after `glob_en` is sampled low, `txd` is high, `te_ack`, `tx_done` and `in_ready` are low, and the held byte is discarded. After re-enabling, frames use the unchanged `bit_div`.
- R9: A byte accepted while a frame is on the line starts its start bit exactly 10·D+1 cycles after the previous start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Block enable; low stops the block and clears flags |
| tx_en | input | 1 | Transmit enable |
| bit_div | input | DIV_W | Clock cycles per bit |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| txd | output | 1 | Serial line, idle high |
| te_ack | output | 1 | Transmit-enable acknowledge |
| tx_done | output | 1 | Transmission complete |

## Verification
The bench checks the exact length of the quiet interval after enabling. A design that skips it, or counts one bit too many, would raise the acknowledge on the wrong edge or start a frame early. It measures start-to-start spacing for back-to-back bytes and for a transmit-enable pulse. A design that drops the idle character, or that lets the held byte jump ahead of it, shows a spacing of 10·D+1 instead of 20·D+2. It also drops the block enable with a byte held and a frame mid-flight. A design that kept stale state would finish the frame or send the held byte after re-enabling, and would leave the completion flag set.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_WAIT  = 3'd1,
        TX_START = 3'd2,
        TX_DATA  = 3'd3,
        TX_STOP  = 3'd4,
        TX_PRE   = 3'd5
    } tx_state_e;

endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
        tick    = run && (q.cnt >= (div_eff - DIV_W'(1)));
        d       = q;
        if (!run || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (q.cnt == '0)); // R1
    AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (q.cnt == '0)); // R8

endmodule

// File: rtl/uart_en_seq.sv
module uart_en_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic glob_en,
    input  logic tx_en,
    input  logic frame_busy,
    input  logic ack_set,
    input  logic pre_take,
    output logic te_rise,
    output logic pre_req,
    output logic ack
);

    typedef struct packed {
        logic te_prev;
        logic ack;
        logic pend;
    } seq_t;

    seq_t q, d;

    always_comb begin
        te_rise = glob_en && tx_en && !q.te_prev;
        pre_req = q.pend || (te_rise && frame_busy);
        d         = q;
        d.te_prev = glob_en && tx_en;
        d.ack     = glob_en && tx_en && (q.ack || ack_set);
        d.pend    = glob_en && !pre_take && pre_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack = q.ack;

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !ack); // R3
    AST_ACK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(ack_set)); // R2

endmodule

// File: rtl/uart_frame_eng.sv
module uart_frame_eng
    import uart_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              tx_en,
    input  logic              ack,
    input  logic              te_rise,
    input  logic              pre_req,
    input  logic              tick,
    input  logic              accept,
    input  logic [DATA_W-1:0] in_data,
    output logic              timer_run,
    output logic              frame_busy,
    output logic              ack_set,
    output logic              pre_take,
    output logic              hold_full,
    output logic              in_pre,
    output logic              done,
    output logic              txd
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int PRE_W = $clog2(PRE_BITS + 1);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic [PRE_W-1:0]  pcnt;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic              done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        ack_set  = 1'b0;
        pre_take = 1'b0;

        if (accept) begin
            d.hold      = in_data;
            d.hold_full = 1'b1;
            d.done      = 1'b0;
        end

        case (q.state)
            TX_IDLE: begin
                if (te_rise) begin
                    d.state = TX_WAIT;
                end else if (tx_en && ack && q.hold_full) begin
                    d.state     = TX_START;
                    d.shreg     = q.hold;
                    d.hold_full = 1'b0;
                end
            end
            TX_WAIT: begin
                if (!tx_en) begin
                    d.state = TX_IDLE;
                end else if (tick) begin
                    d.state = TX_IDLE;
                    ack_set = 1'b1;
                end
            end
            TX_START: begin
                if (tick) begin
                    d.state = TX_DATA;
                    d.idx   = '0;
                end
            end
            TX_DATA: begin
                if (tick) begin
                    d.shreg = q.shreg >> 1;
                    if (q.idx == IDX_W'(DATA_W - 1)) d.state = TX_STOP;
                    else                            d.idx   = q.idx + IDX_W'(1);
                end
            end
            TX_STOP: begin
                if (tick) begin
                    pre_take = 1'b1;
                    if (pre_req && tx_en) begin
                        d.state = TX_PRE;
                        d.pcnt  = '0;
                    end else begin
                        d.state = TX_IDLE;
                        if (!d.hold_full) d.done = 1'b1;
                    end
                end
            end
            TX_PRE: begin
                if (tick) begin
                    if (q.pcnt == PRE_W'(PRE_BITS - 1)) begin
                        d.state = TX_IDLE;
                        ack_set = 1'b1;
                        if (!d.hold_full) d.done = 1'b1;
                    end else begin
                        d.pcnt = q.pcnt + PRE_W'(1);
                    end
                end
            end
            default: d.state = TX_IDLE;
        endcase

        if (!glob_en) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        timer_run  = glob_en && (q.state != TX_IDLE);
        frame_busy = (q.state == TX_START) || (q.state == TX_DATA) || (q.state == TX_STOP);
        in_pre     = (q.state == TX_PRE);
        hold_full  = q.hold_full;
        done       = q.done;
        txd        = (q.state != TX_START) && ((q.state != TX_DATA) || q.shreg[0]);
    end

    AST_START_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_START && $past(q.state) == TX_IDLE) |-> $past(ack)); // R2
    AST_PRE_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == TX_PRE && $past(q.state) != TX_PRE) |-> ($past(q.state) == TX_STOP)); // R5
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!glob_en) |-> (q.state == TX_IDLE && !q.done && !q.hold_full)); // R8

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 16,
    parameter int PRE_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              te_ack,
    output logic              tx_done
);

    logic tick, timer_run, frame_busy, ack_set, pre_take;
    logic te_rise, pre_req, ack, hold_full, in_pre, accept;

    uart_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .divisor (bit_div),
        .tick    (tick)
    );

    uart_en_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .glob_en    (glob_en),
        .tx_en      (tx_en),
        .frame_busy (frame_busy),
        .ack_set    (ack_set),
        .pre_take   (pre_take),
        .te_rise    (te_rise),
        .pre_req    (pre_req),
        .ack        (ack)
    );

    uart_frame_eng #(.DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .glob_en    (glob_en),
        .tx_en      (tx_en),
        .ack        (ack),
        .te_rise    (te_rise),
        .pre_req    (pre_req),
        .tick       (tick),
        .accept     (accept),
        .in_data    (in_data),
        .timer_run  (timer_run),
        .frame_busy (frame_busy),
        .ack_set    (ack_set),
        .pre_take   (pre_take),
        .hold_full  (hold_full),
        .in_pre     (in_pre),
        .done       (tx_done),
        .txd        (txd)
    );

    assign in_ready = glob_en && tx_en && ack && !hold_full && !in_pre;
    assign accept   = in_valid && in_ready;
    assign te_ack   = ack;

    AST_ACCEPT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_done); // R7
    AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> txd); // R8

endmodule

// File: tb/uart_tx_seq_bench.sv
module uart_tx_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        glob_en, tx_en, in_valid;
    logic [15:0] bit_div;
    logic [7:0]  in_data;
    logic        in_ready, txd, te_ack, tx_done;

    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    int          dcur = 4;
    int          frames_seen = 0;
    int          last_start = 0;
    int          prev_start = 0;
    bit          mon_en = 1'b1;
    logic [7:0]  exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_seq u_uart_tx_seq (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .tx_en(tx_en),
        .bit_div(bit_div), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .txd(txd), .te_ack(te_ack), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit expect_it);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        if (expect_it) exp_q.push_back(b);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_ack();
        repeat (dcur + 2) @(negedge clk);
    endtask

    // Monitor: decode frames on txd and compare with the scoreboard queue (R1)
    initial begin
        logic [7:0] got;
        logic       stopb;
        logic [7:0] expb;
        forever begin
            @(negedge clk);
            if (mon_en && txd == 1'b0) begin
                prev_start = last_start;
                last_start = cyc;
                repeat (dcur / 2) @(negedge clk);
                chk(txd == 1'b0, "R1 start bit", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (dcur) @(negedge clk);
                    got[i] = txd;
                end
                repeat (dcur) @(negedge clk);
                stopb = txd;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected frame", int'(got), -1);
                end else begin
                    expb = exp_q.pop_front();
                    chk(got == expb, "R1 frame data", int'(got), int'(expb));
                    chk(stopb == 1'b1, "R1 stop bit", int'(stopb), 1);
                end
                frames_seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int target;
        rst_n = 1'b0; glob_en = 1'b0; tx_en = 1'b0; in_valid = 1'b0;
        in_data = 8'h00; bit_div = 16'd4; dcur = 4;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R8 reset line high", int'(txd), 1);
        chk(in_ready == 1'b0, "R4 reset ready low", int'(in_ready), 0);
        chk(te_ack == 1'b0, "R3 reset ack low", int'(te_ack), 0);
        chk(tx_done == 1'b0, "R7 reset done low", int'(tx_done), 0);

        // R2: acknowledge after one bit time
        glob_en = 1'b1; tx_en = 1'b1;
        repeat (dcur) @(posedge clk);
        @(negedge clk);
        chk(te_ack == 1'b0, "R2 ack still low at E0+D-1", int'(te_ack), 0);
        chk(txd == 1'b1, "R2 line quiet during delay", int'(txd), 1);
        @(posedge clk);
        @(negedge clk);
        chk(te_ack == 1'b1, "R2 ack high at E0+D", int'(te_ack), 1);
        chk(in_ready == 1'b1, "R4 ready when armed", int'(in_ready), 1);

        // R1 / R7 single frame
        target = frames_seen + 1;
        send(8'hA5, 1'b1);
        chk(tx_done == 1'b0, "R7 done low after accept", int'(tx_done), 0);
        wait (frames_seen == target);
        repeat (dcur) @(negedge clk);
        chk(tx_done == 1'b1, "R7 done after last frame", int'(tx_done), 1);

        // R9 / R4 back-to-back
        target = frames_seen + 2;
        send(8'h00, 1'b1);
        send(8'hFF, 1'b1);
        chk(in_ready == 1'b0, "R4 ready low with byte held", int'(in_ready), 0);
        wait (frames_seen == target);
        chk(last_start - prev_start == 10 * dcur + 1, "R9 start spacing",
            last_start - prev_start, 10 * dcur + 1);

        // R1 odd divisor
        repeat (dcur) @(negedge clk);
        bit_div = 16'd7; dcur = 7;
        target = frames_seen + 2;
        send(8'h01, 1'b1);
        send(8'h80, 1'b1);
        wait (frames_seen == target);
        chk(last_start - prev_start == 10 * dcur + 1, "R9 start spacing odd D",
            last_start - prev_start, 10 * dcur + 1);
        repeat (dcur) @(negedge clk);
        bit_div = 16'd4; dcur = 4;

        // R5 preamble after a transmit-enable pulse
        target = frames_seen + 2;
        send(8'h5A, 1'b1);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        tx_en = 1'b1;
        repeat (10 * dcur + 2) @(negedge clk);
        chk(txd == 1'b1, "R5 line high in preamble", int'(txd), 1);
        chk(in_ready == 1'b0, "R4 ready low in preamble", int'(in_ready), 0);
        chk(te_ack == 1'b0, "R5 ack low in preamble", int'(te_ack), 0);
        send(8'hC3, 1'b1);
        wait (frames_seen == target);
        chk(last_start - prev_start == 20 * dcur + 2, "R5 start spacing with preamble",
            last_start - prev_start, 20 * dcur + 2);
        chk(te_ack == 1'b1, "R5 ack back after preamble", int'(te_ack), 1);
        repeat (dcur) @(negedge clk);

        // R6 / R3 transmit enable dropped for good
        target = frames_seen + 1;
        send(8'h96, 1'b1);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(te_ack == 1'b0, "R3 ack drops with tx_en", int'(te_ack), 0);
        wait (frames_seen == target);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 30 * dcur; i++) begin
                @(negedge clk);
                if (txd != 1'b1 || in_ready != 1'b0) quiet = 1'b0;
            end
            chk(quiet, "R6 line stays idle after disable", int'(quiet), 1);
        end
        chk(tx_done == 1'b1, "R7 done after final frame", int'(tx_done), 1);

        // R8 block enable clears flags
        tx_en = 1'b1;
        wait_ack();
        glob_en = 1'b0;
        @(negedge clk);
        chk(tx_done == 1'b0, "R8 done cleared", int'(tx_done), 0);
        chk(te_ack == 1'b0, "R8 ack cleared", int'(te_ack), 0);
        glob_en = 1'b1;
        wait_ack();
        mon_en = 1'b0;
        send(8'hE7, 1'b0);
        send(8'h18, 1'b0);
        repeat (3 * dcur) @(negedge clk);
        glob_en = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R8 line high after disable", int'(txd), 1);
        chk(in_ready == 1'b0, "R8 ready low after disable", int'(in_ready), 0);
        chk(te_ack == 1'b0, "R8 ack low after disable", int'(te_ack), 0);
        glob_en = 1'b1;
        mon_en  = 1'b1;
        target  = frames_seen;
        wait_ack();
        repeat (12 * dcur) @(negedge clk);
        chk(frames_seen == target, "R8 held byte discarded", frames_seen, target);
        target = frames_seen + 1;
        send(8'h42, 1'b1);
        wait (frames_seen == target);
        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule